// File: doc/BRIEF.md
# PWM Generator Channel with Dead-Band Insertion

This block is one channel of a pulse-width modulator. A 16-bit counter runs either downward (reloading from a period value) or up and then down between zero and the period value. The counter raises an event when it is at zero and another when it equals the period value. Two comparators raise events when the count equals their thresholds. Two output generators each hold a table of actions, one per event, and use it to set, clear or invert their level. A dead-band stage can turn generator A into a pair of complementary half-bridge drives, each with a delayed rising edge. When that stage is off, both generator levels pass through unchanged. A per-pin enable then gates the registered pins.

A host programs the channel through a write-only register port with a 3-bit address and a 16-bit data word. Period and threshold writes either take effect at once or wait in a shadow register until the counter next reaches zero. This avoids a glitched cycle when the duty or period changes while the channel runs.

Top module: `pwm_gen_db`

## Requirements
- R1: After reset, and while the run bit (control register at address 0, bit 0) is 0, both pins are low and the counter is held at zero. The dead-band delay counts are also held at zero.
- R2: With the mode bit (control bit 1) at 0, the count after start is 0, then the period value P (address 1), then P-1 down to 0, and it repeats with a period of P+1 cycles. Each reload at zero uses the newest written period value.
- R3: With the mode bit at 1 and P at least 1, the count runs 0, 1 … P, P-1 … 1 and repeats with a period of 2P cycles. A comparator match while the count is rising selects that comparator's up action, and any other match selects its down action. The count 0 counts as rising and the count P counts as falling. In down mode only the down actions are used.
- R4: Each generator has a 12-bit action word (A at address 4, B at address 5) made of six 2-bit codes. Bits [1:0] act on zero, [3:2] on period, [5:4] on comparator A up, [7:6] on comparator A down, [9:8] on comparator B up and [11:10] on comparator B down. Code 00 keeps the level, 01 inverts it, 10 drives it low and 11 drives it high. With no event the level holds. The thresholds for comparators A and B are written at addresses 2 and 3.
- R5: When several events occur in one cycle, only the non-keep code at the highest field position is applied.
- R6: An event in a given cycle shows on the pins two clock cycles later.
- R7: With its sync bit at 0 (control bit 2 for the period, bit 3 for both thresholds), a written value is used from the cycle after the write.
- R8: With its sync bit at 1, a value written while the channel runs waits in a shadow register. It becomes active in the cycle after the counter is next at zero.
- R9: With dead-band on (control bit 4), pin A follows generator A with its rising edge delayed by the rise count (address 6). Pin B follows the inverse of generator A with its rising edge delayed by the fall count (address 7). A pulse shorter than its delay is removed, and the two pins are never high together.
- R10: With dead-band off, pin A follows generator A and pin B follows generator B.
- R11: A pin whose enable bit is 0 (control bit 5 for A, bit 6 for B) stays low, and the other pin is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Registered PWM pin A |
| pwm_b | output | 1 | Registered PWM pin B |

## Verification
The action logic is swept over both counting modes, every period from 1 to 5, and every threshold from 0 up to the period. Comparator B is set to the mirror threshold, so its matches sometimes coincide with comparator A, with zero or with the period value. Four action tables are used: set and clear, toggle-only, mixed, and tables with deliberate conflicts. Together they separate up matches from down matches, the action codes from each other, and the priority order.

The dead-band stage is tried with every rise and fall count from 0 to 3. Short pulses show whether pulses are swallowed correctly and whether any overlap occurs. Mid-period writes of the period and threshold, in both sync settings and both modes, show whether a new value lands at once or at the next zero. The enable combinations confirm that each pin is gated on its own.

// File: rtl/pwm_db_pkg.sv
// Shared definitions for the PWM channel: action codes, event indices,
// register addresses and control-bit positions.
package pwm_db_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLR    = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    // Event indices; a higher index has higher priority.
    localparam int EV_N    = 6;
    localparam int ACT_W   = 2 * EV_N;
    localparam int EV_ZERO = 0;
    localparam int EV_PER  = 1;
    localparam int EV_AUP  = 2;
    localparam int EV_ADN  = 3;
    localparam int EV_BUP  = 4;
    localparam int EV_BDN  = 5;

    // Register addresses.
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_PER  = 3'd1;
    localparam logic [2:0] RA_THA  = 3'd2;
    localparam logic [2:0] RA_THB  = 3'd3;
    localparam logic [2:0] RA_ACTA = 3'd4;
    localparam logic [2:0] RA_ACTB = 3'd5;
    localparam logic [2:0] RA_RISE = 3'd6;
    localparam logic [2:0] RA_FALL = 3'd7;

    // Control-bit positions.
    localparam int CB_RUN   = 0;
    localparam int CB_UPDN  = 1;
    localparam int CB_PSYNC = 2;
    localparam int CB_TSYNC = 3;
    localparam int CB_DB    = 4;
    localparam int CB_ENA   = 5;
    localparam int CB_ENB   = 6;
    localparam int CTRL_W   = 7;

    // Apply one action code to the current level.
    function automatic logic apply_act(input act_e code, input logic cur);
        case (code)
            ACT_TOGGLE: return ~cur;
            ACT_CLR:    return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_counter.sv
// Period counter. It counts down from the period value, or up and down
// between zero and the period value. It flags the zero and period points
// and reports the direction of travel.
// Assumes: the period is at least 1 in up/down mode. The reload at zero takes
// the shadow period, which equals the active one except for a pending sync update.
module pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         updown,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] per_sh,
    output logic [W-1:0] cnt,
    output logic         rising,
    output logic         at_zero,
    output logic         at_per
);

    logic dir_q;

    // Decode the counter points and the direction of the current step.
    always_comb begin
        at_zero = run && (cnt == '0);
        at_per  = run && (cnt == per_act);
        rising  = updown && ((cnt == '0) || (dir_q && (cnt < per_act)));
    end

    // Advance the count according to the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            dir_q <= 1'b1;
        end else begin
            dir_q <= rising;
            if (!updown)
                cnt <= (cnt == '0) ? per_sh : cnt - 1'b1;
            else if (rising)
                cnt <= (per_act == '0) ? '0 : cnt + 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

    p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !updown && cnt != '0) |=> (!run || updown || cnt == $past(cnt) - 1'b1));

    p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !updown && cnt == '0) |=> (!run || updown || cnt == $past(per_sh)));

    p_ud_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && updown && cnt == per_act && per_act != '0)
            |=> (!run || !updown || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pwm_action.sv
// Output generator. For every cycle it picks the highest-priority
// non-keep action among the active events and applies it to the level.
// Assumes: events are single-cycle decodes of the current count; the level is cleared while stopped.
module pwm_action
    import pwm_db_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EV_N-1:0]  ev,
    input  logic [ACT_W-1:0] acts,
    output logic             lvl
);

    act_e sel;

    // Pick the winning action; a later field overrides an earlier one.
    always_comb begin
        sel = ACT_KEEP;
        for (int i = 0; i < EV_N; i++) begin
            if (ev[i] && (act_e'(acts[2*i +: 2]) != ACT_KEEP))
                sel = act_e'(acts[2*i +: 2]);
        end
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            lvl <= 1'b0;
        else
            lvl <= apply_act(sel, lvl);
    end

    p_no_event_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ev == '0) |=> (!run || $stable(lvl)));

endmodule

// File: rtl/pwm_edge_delay.sv
// Rising-edge delay. The output goes high only after the input has been
// high for dly consecutive cycles, and it drops together with the input.
// Assumes: the delay count may change at any time; the output compares against the present value.
module pwm_edge_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          src,
    input  logic [DW-1:0] dly,
    output logic          out
);

    logic [DW-1:0] hold_cnt;

    // Count how long the input has been high, saturating at the delay.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !src)
            hold_cnt <= '0;
        else if (hold_cnt < dly)
            hold_cnt <= hold_cnt + 1'b1;
    end

    assign out = src && (hold_cnt >= dly);

    p_delay_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out) && dly != '0) |-> $past(src));

endmodule

// File: rtl/pwm_deadband.sv
// Dead-band stage. When enabled, it forms a complementary pair from
// generator A, each side with its own rising-edge delay. When disabled,
// it passes both generator levels through.
// Assumes: the levels come from registers, so the outputs are glitch-free before the pin register.
module pwm_deadband #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          db_on,
    input  logic          gen_a,
    input  logic          gen_b,
    input  logic [DW-1:0] rise,
    input  logic [DW-1:0] fall,
    output logic          out_a,
    output logic          out_b
);

    logic hi_side;
    logic lo_side;

    pwm_edge_delay #(.DW(DW)) u_hi (
        .clk(clk), .rst_n(rst_n), .run(run), .src(gen_a), .dly(rise), .out(hi_side)
    );

    pwm_edge_delay #(.DW(DW)) u_lo (
        .clk(clk), .rst_n(rst_n), .run(run), .src(~gen_a), .dly(fall), .out(lo_side)
    );

    // Choose between the delayed pair and the straight levels.
    always_comb begin
        out_a = db_on ? hi_side : gen_a;
        out_b = db_on ? lo_side : gen_b;
    end

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        db_on |-> !(out_a && out_b));

endmodule

// File: rtl/pwm_gen_db.sv
// PWM channel top. It holds the register file, the shadow and active
// copies of the period and thresholds, the event decode and the enabled pin registers.
// Assumes: registers are write-only; values written while stopped take effect before the next start.
module pwm_gen_db
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int N_CMP = 2;
    localparam int N_GEN = 2;

    logic [CTRL_W-1:0] ctrl;
    logic [CNT_W-1:0]  per_sh, per_act;
    logic [CNT_W-1:0]  th_sh  [N_CMP];
    logic [CNT_W-1:0]  th_act [N_CMP];
    logic [ACT_W-1:0]  act_cfg [N_GEN];
    logic [DB_W-1:0]   rise_q, fall_q;

    logic              run, updown, psync, tsync;
    logic              wr_per;
    logic [N_CMP-1:0]  wr_th;
    logic [CNT_W-1:0]  cnt;
    logic              rising, at_zero, at_per;
    logic [EV_N-1:0]   ev;
    logic [N_GEN-1:0]  gen_lvl;
    logic              db_a, db_b;

    assign run    = ctrl[CB_RUN];
    assign updown = ctrl[CB_UPDN];
    assign psync  = ctrl[CB_PSYNC];
    assign tsync  = ctrl[CB_TSYNC];
    assign wr_per = wr_en && (wr_addr == RA_PER);
    assign wr_th  = {wr_en && (wr_addr == RA_THB), wr_en && (wr_addr == RA_THA)};

    // Host writes to the control, shadow, action and delay registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            per_sh     <= '0;
            th_sh[0]   <= '0;
            th_sh[1]   <= '0;
            act_cfg[0] <= '0;
            act_cfg[1] <= '0;
            rise_q     <= '0;
            fall_q     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL: ctrl       <= wr_data[CTRL_W-1:0];
                RA_PER:  per_sh     <= wr_data;
                RA_THA:  th_sh[0]   <= wr_data;
                RA_THB:  th_sh[1]   <= wr_data;
                RA_ACTA: act_cfg[0] <= wr_data[ACT_W-1:0];
                RA_ACTB: act_cfg[1] <= wr_data[ACT_W-1:0];
                RA_RISE: rise_q     <= wr_data[DB_W-1:0];
                default: fall_q     <= wr_data[DB_W-1:0];
            endcase
        end
    end

    // Active period: direct on an unsynced write, else copied at zero or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_act <= '0;
        else if (wr_per && !psync)
            per_act <= wr_data;
        else if (!run || at_zero)
            per_act <= per_sh;
    end

    // Active thresholds, one update path per comparator.
    for (genvar c = 0; c < N_CMP; c++) begin : g_thr
        always_ff @(posedge clk) begin
            if (!rst_n)
                th_act[c] <= '0;
            else if (wr_th[c] && !tsync)
                th_act[c] <= wr_data;
            else if (!run || at_zero)
                th_act[c] <= th_sh[c];
        end
    end

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .updown(updown),
        .per_act(per_act), .per_sh(per_sh), .cnt(cnt),
        .rising(rising), .at_zero(at_zero), .at_per(at_per)
    );

    // Build the event vector from the counter points and the comparator matches.
    always_comb begin
        ev          = '0;
        ev[EV_ZERO] = at_zero;
        ev[EV_PER]  = at_per;
        for (int c = 0; c < N_CMP; c++) begin
            ev[EV_AUP + 2*c] = run && (cnt == th_act[c]) && rising;
            ev[EV_ADN + 2*c] = run && (cnt == th_act[c]) && !rising;
        end
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        pwm_action u_act (
            .clk(clk), .rst_n(rst_n), .run(run), .ev(ev),
            .acts(act_cfg[g]), .lvl(gen_lvl[g])
        );
    end

    pwm_deadband #(.DW(DB_W)) u_db (
        .clk(clk), .rst_n(rst_n), .run(run), .db_on(ctrl[CB_DB]),
        .gen_a(gen_lvl[0]), .gen_b(gen_lvl[1]),
        .rise(rise_q), .fall(fall_q), .out_a(db_a), .out_b(db_b)
    );

    // Pin registers, gated by the run bit and the per-pin enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_a <= 1'b0;
            pwm_b <= 1'b0;
        end else begin
            pwm_a <= run && ctrl[CB_ENA] && db_a;
            pwm_b <= run && ctrl[CB_ENB] && db_b;
        end
    end

    p_pins_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pwm_a && !pwm_b));

    p_per_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && psync && !at_zero && !wr_per) |=> (!run || $stable(per_act)));

endmodule

// File: tb/pwm_gen_db_test.sv
// Self-checking bench. A per-cycle model written from the requirements
// predicts both pins; sweeps cover modes, periods, thresholds, action tables,
// delays, enables and mid-run updates.
module pwm_gen_db_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;

    // model configuration
    int m_upd, m_psync, m_tsync, m_db, m_ena, m_enb, m_per, m_tha, m_thb, m_rise, m_fall;
    logic [11:0] m_act [2];

    always #10 clk = ~clk;

    pwm_gen_db uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input int run);
        return 16'(run | (m_upd << 1) | (m_psync << 2) | (m_tsync << 3) |
                   (m_db << 4) | (m_ena << 5) | (m_enb << 6));
    endfunction

    function automatic logic apply(input logic [1:0] code, input logic cur);
        case (code)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    task automatic configure();
        wr(3'd0, ctrl_word(0));
        wr(3'd1, 16'(m_per));
        wr(3'd2, 16'(m_tha));
        wr(3'd3, 16'(m_thb));
        wr(3'd4, {4'd0, m_act[0]});
        wr(3'd5, {4'd0, m_act[1]});
        wr(3'd6, 16'(m_rise));
        wr(3'd7, 16'(m_fall));
        @(negedge clk);
        @(negedge clk);
    endtask

    // Start the channel, step the model and compare the pins each cycle.
    task automatic run_case(input int n, input int wr_at, input logic [2:0] wa,
                            input int wv, input string tag);
        int cnt, dir, hl, ll, per_s, per_a;
        int th_s [2];
        int th_a [2];
        logic q [2];
        logic expv [2];
        logic o [2];
        logic [5:0] ev;
        cnt = 0; dir = 1; hl = 0; ll = 0;
        per_s = m_per; per_a = m_per;
        th_s[0] = m_tha; th_s[1] = m_thb; th_a[0] = m_tha; th_a[1] = m_thb;
        q[0] = 1'b0; q[1] = 1'b0; expv[0] = 1'b0; expv[1] = 1'b0;
        wr(3'd0, ctrl_word(1));
        for (int j = 0; j < n; j++) begin
            int up, nper_a, ncnt;
            int nth_a [2];
            if (j > 0) @(negedge clk);
            if (j == wr_at) begin
                wr_en = 1'b1; wr_addr = wa; wr_data = 16'(wv);
            end else begin
                wr_en = 1'b0;
            end
            check(tag, "pin a", pwm_a, expv[0]);
            check(tag, "pin b", pwm_b, expv[1]);
            if (m_db != 0) check("R9", "overlap", pwm_a && pwm_b, 1'b0);
            // events of this cycle
            up = (m_upd != 0 && (cnt == 0 || (dir != 0 && cnt < per_a))) ? 1 : 0;
            ev[0] = (cnt == 0);
            ev[1] = (cnt == per_a);
            for (int c = 0; c < 2; c++) begin
                ev[2 + 2*c] = (cnt == th_a[c]) && (up != 0);
                ev[3 + 2*c] = (cnt == th_a[c]) && (up == 0);
            end
            // dead-band view of this cycle's generator levels
            hl = q[0] ? hl + 1 : 0;
            ll = q[0] ? 0 : ll + 1;
            o[0] = (m_db != 0) ? (q[0] && (hl - 1 >= m_rise)) : q[0];
            o[1] = (m_db != 0) ? (!q[0] && (ll - 1 >= m_fall)) : q[1];
            expv[0] = (m_ena != 0) && o[0];
            expv[1] = (m_enb != 0) && o[1];
            // generator levels for the next cycle
            for (int g = 0; g < 2; g++) begin
                logic [1:0] code;
                code = 2'b00;
                for (int e = 0; e < 6; e++)
                    if (ev[e] && m_act[g][2*e +: 2] != 2'b00) code = m_act[g][2*e +: 2];
                q[g] = apply(code, q[g]);
            end
            // counter
            if (m_upd == 0) ncnt = (cnt == 0) ? per_s : cnt - 1;
            else if (up != 0) ncnt = (per_a == 0) ? 0 : cnt + 1;
            else ncnt = cnt - 1;
            // active values
            nper_a = per_a;
            if (j == wr_at && wa == 3'd1 && m_psync == 0) nper_a = wv;
            else if (cnt == 0) nper_a = per_s;
            for (int c = 0; c < 2; c++) begin
                nth_a[c] = th_a[c];
                if (j == wr_at && wa == 3'(2 + c) && m_tsync == 0) nth_a[c] = wv;
                else if (cnt == 0) nth_a[c] = th_s[c];
            end
            if (j == wr_at && wa == 3'd1) per_s = wv;
            if (j == wr_at && wa == 3'd2) th_s[0] = wv;
            if (j == wr_at && wa == 3'd3) th_s[1] = wv;
            per_a = nper_a; th_a[0] = nth_a[0]; th_a[1] = nth_a[1];
            cnt = ncnt; dir = up;
        end
        @(negedge clk);
        wr_en = 1'b0;
        wr(3'd0, ctrl_word(0));
        @(negedge clk);
        check("R1", "pin a stopped", pwm_a, 1'b0);
        check("R1", "pin b stopped", pwm_b, 1'b0);
    endtask

    function automatic logic [11:0] pattern(input int s, input int g);
        // field order {B dn, B up, A dn, A up, period, zero}
        case (s * 2 + g)
            0: return 12'b00_00_10_10_00_11;
            1: return 12'b11_11_00_00_00_10;
            2: return 12'b00_00_00_00_01_01;
            3: return 12'b10_00_00_11_00_00;
            4: return 12'b11_00_00_01_10_11;
            5: return 12'b01_01_01_01_01_01;
            6: return 12'b10_11_11_10_00_00;
            default: return 12'b00_00_10_00_11_11;
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1", "pin a in reset", pwm_a, 1'b0);
        check("R1", "pin b in reset", pwm_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pin a after reset", pwm_a, 1'b0);
        check("R1", "pin b after reset", pwm_b, 1'b0);

        // R2 R3 R4 R5 R6 R10: action sweep with dead-band off
        m_psync = 0; m_tsync = 0; m_db = 0; m_ena = 1; m_enb = 1; m_rise = 0; m_fall = 0;
        for (int md = 0; md < 2; md++)
            for (int per = 1; per <= 5; per++)
                for (int tha = 0; tha <= per; tha++)
                    for (int s = 0; s < 4; s++) begin
                        m_upd = md; m_per = per; m_tha = tha; m_thb = per - tha;
                        m_act[0] = pattern(s, 0); m_act[1] = pattern(s, 1);
                        configure();
                        run_case((md != 0) ? 6 * per + 3 : 3 * (per + 1) + 3, -1, 3'd0, 0,
                                 (md != 0) ? "R3/R4/R5/R6/R10" : "R2/R4/R5/R6/R10");
                    end

        // R9: dead-band with every rise and fall count from 0 to 3
        m_db = 1;
        for (int md = 0; md < 2; md++)
            for (int r = 0; r < 4; r++)
                for (int f = 0; f < 4; f++) begin
                    m_upd = md; m_per = 7; m_tha = (md != 0) ? 5 : 2; m_thb = 1;
                    m_rise = r; m_fall = f;
                    m_act[0] = pattern(0, 0); m_act[1] = pattern(0, 1);
                    configure();
                    run_case(40, -1, 3'd0, 0, "R9");
                end

        // R11: enable combinations
        m_db = 0; m_rise = 0; m_fall = 0;
        for (int e = 0; e < 4; e++) begin
            m_upd = 1; m_per = 4; m_tha = 1; m_thb = 3;
            m_ena = e & 1; m_enb = (e >> 1) & 1;
            m_act[0] = pattern(0, 0); m_act[1] = pattern(0, 1);
            configure();
            run_case(30, -1, 3'd0, 0, "R11");
        end

        // R7 R8: mid-period threshold and period updates, both sync settings
        m_ena = 1; m_enb = 1;
        for (int md = 0; md < 2; md++)
            for (int sy = 0; sy < 2; sy++)
                for (int tgt = 0; tgt < 2; tgt++) begin
                    m_upd = md; m_per = (md != 0) ? 6 : 9; m_tha = (md != 0) ? 4 : 6; m_thb = 2;
                    m_psync = sy; m_tsync = sy;
                    m_act[0] = pattern(0, 0); m_act[1] = pattern(0, 1);
                    configure();
                    run_case(48, (md != 0) ? 4 : 3, (tgt != 0) ? 3'd1 : 3'd2,
                             (tgt != 0) ? 3 : 2, (sy != 0) ? "R8" : "R7");
                end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule